// File: doc/BRIEF.md
# Multi-Function Integer Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a datapath. It takes two operands of `W` bits (32 by default), read as two's-complement numbers, and a 4-bit operation selector. In the same evaluation it returns a `W`-bit result and three flags: zero, carry-out and signed overflow. It has no clock, no state and no handshake. A surrounding pipeline registers its inputs and outputs as needed.

The unit offers add, subtract, bitwise NAND, bitwise OR and inversion of the first operand. It also offers single-position shifts and rotates of the first operand: arithmetic right, logical right, logical left, rotate left and rotate right. The selector space is sparse. Every code without an assigned operation returns a defined all-zero result.

Top module: `alu32_core`

## Requirements
- R1: Code 4'b0000 returns A+B modulo 2^W, carry_o is bit W of the unsigned sum, and ovf_o is 1 exactly when A and B share a sign that differs from the sign of the result.
- R2: Code 4'b0001 returns A-B modulo 2^W, carry_o is the carry out of A + ~B + 1 (1 when A >= B unsigned), and ovf_o is 1 exactly when A and B differ in sign and the result sign differs from the sign of A.
- R3: Code 4'b0010 returns the bitwise NAND of A and B, and code 4'b0011 returns the bitwise OR.
- R4: Code 4'b0100 returns the bitwise inverse of A, and B has no effect on any output.
- R5: Code 4'b1000 shifts A right by one and copies the old MSB into the new MSB. Code 4'b1001 shifts A right by one and puts 0 into the MSB.
- R6: Code 4'b1010 shifts A left by one and puts 0 into the LSB.
- R7: Code 4'b1100 rotates A left by one, so the old MSB lands in bit 0. Code 4'b1101 rotates A right by one, so the old bit 0 lands in the MSB.
- R8: zero_o is 1 exactly when res_o is all zeros, for every code.
- R9: For every code other than 4'b0000 and 4'b0001, carry_o and ovf_o are 0.
- R10: Every unassigned code (0101, 0110, 0111, 1011, 1110, 1111) returns a result of 0, which also sets zero_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | W | First operand, two's complement |
| opb_i | input | W | Second operand, two's complement |
| op_i | input | 4 | Operation selector |
| res_o | output | W | Result |
| zero_o | output | 1 | Result equals zero |
| carry_o | output | 1 | Carry-out of add or subtract |
| ovf_o | output | 1 | Signed overflow of add or subtract |

## Verification
The zero flag and the arithmetic flags can assert on the same evaluation. For example, adding 0x8000_0000 to itself wraps to zero, which raises zero, carry and overflow together. Subtracting equal operands raises zero and carry without overflow. The bench drives these directed operand pairs and also draws random operands biased toward sign-boundary values. It compares all four outputs together against a reference function, so a result that is right but carries a wrong flag on that same evaluation is still reported.

// File: rtl/alu32_pkg.sv
package alu32_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000,
    OP_SUB  = 4'b0001,
    OP_NAND = 4'b0010,
    OP_OR   = 4'b0011,
    OP_INV  = 4'b0100,
    OP_SRA  = 4'b1000,
    OP_SRL  = 4'b1001,
    OP_SLL  = 4'b1010,
    OP_ROL  = 4'b1100,
    OP_ROR  = 4'b1101
  } alu_op_e;

  typedef enum logic [1:0] {
    GRP_ARITH = 2'd0,
    GRP_LOGIC = 2'd1,
    GRP_SHIFT = 2'd2,
    GRP_NONE  = 2'd3
  } alu_grp_e;
endpackage

// File: rtl/alu32_addsub.sv
module alu32_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    wide   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
    sum_o  = wide[W-1:0];
    cout_o = wide[W];
    // signed overflow: effective operands agree in sign, result disagrees
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu32_logic.sv
module alu32_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   sel_i,
  output logic [W-1:0] y_o
);
  // sel: 2 -> NAND, 3 -> OR, 0 -> invert A
  always_comb begin
    unique case (sel_i)
      2'd2:    y_o = ~(a_i & b_i);
      2'd3:    y_o = a_i | b_i;
      default: y_o = ~a_i;
    endcase
  end
endmodule

// File: rtl/alu32_shift.sv
module alu32_shift #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [2:0]   sel_i,
  output logic [W-1:0] y_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] right_v;
  logic [W-1:0] left_v;
  logic         fill_hi;
  logic         fill_lo;

  // sel: 0 sra, 1 srl, 2 sll, 4 rol, 5 ror
  always_comb begin
    unique case (sel_i)
      3'd0:    fill_hi = a_i[MSB];
      3'd5:    fill_hi = a_i[0];
      default: fill_hi = 1'b0;
    endcase
    fill_lo = (sel_i == 3'd4) ? a_i[MSB] : 1'b0;
  end

  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_bits
      assign right_v[i]  = a_i[i+1];
      assign left_v[i+1] = a_i[i];
    end
  endgenerate

  assign right_v[MSB] = fill_hi;
  assign left_v[0]    = fill_lo;

  always_comb begin
    unique case (sel_i)
      3'd2, 3'd4: y_o = left_v;
      default:    y_o = right_v;
    endcase
  end
endmodule

// File: rtl/alu32_core.sv
module alu32_core
  import alu32_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o
);
  alu_grp_e     grp;
  logic [W-1:0] arith_y;
  logic [W-1:0] logic_y;
  logic [W-1:0] shift_y;
  logic         arith_c;
  logic         arith_v;

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB:          grp = GRP_ARITH;
      OP_NAND, OP_OR, OP_INV:  grp = GRP_LOGIC;
      OP_SRA, OP_SRL, OP_SLL,
      OP_ROL, OP_ROR:          grp = GRP_SHIFT;
      default:                 grp = GRP_NONE;
    endcase
  end

  alu32_addsub #(.W(W)) u_addsub (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .sub_i (op_i[0]),
    .sum_o (arith_y),
    .cout_o(arith_c),
    .ovf_o (arith_v)
  );

  alu32_logic #(.W(W)) u_logic (
    .a_i  (opa_i),
    .b_i  (opb_i),
    .sel_i(op_i[1:0]),
    .y_o  (logic_y)
  );

  alu32_shift #(.W(W)) u_shift (
    .a_i  (opa_i),
    .sel_i(op_i[2:0]),
    .y_o  (shift_y)
  );

  always_comb begin
    res_o   = '0;
    carry_o = 1'b0;
    ovf_o   = 1'b0;
    unique case (grp)
      GRP_ARITH: begin
        res_o   = arith_y;
        carry_o = arith_c;
        ovf_o   = arith_v;
      end
      GRP_LOGIC: res_o = logic_y;
      GRP_SHIFT: res_o = shift_y;
      default:   res_o = '0;
    endcase
    zero_o = (res_o == '0);
  end
endmodule

// File: rtl/alu32_checks.sv
module alu32_checks #(
  parameter int W = 32
) (
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] res_o,
  input logic         zero_o,
  input logic         carry_o,
  input logic         ovf_o
);
  logic arith;
  logic unassigned;

  always_comb begin
    arith      = (op_i == 4'b0000) || (op_i == 4'b0001);
    unassigned = (op_i inside {4'b0101, 4'b0110, 4'b0111,
                               4'b1011, 4'b1110, 4'b1111});
  end

  always_comb begin
    a_r8_zero_flag: assert (zero_o == ~|res_o)
      else $error("zero flag mismatch");
    if (!arith) begin
      a_r9_flags_quiet: assert (!carry_o && !ovf_o)
        else $error("flags set outside add/sub");
    end
    if (unassigned) begin
      a_r10_unassigned_zero: assert (res_o == '0 && zero_o)
        else $error("unassigned code nonzero");
    end
    if (op_i == 4'b0100) begin
      a_r4_invert: assert (&(res_o ^ opa_i))
        else $error("invert wrong");
    end
    if (op_i == 4'b1100) begin
      a_r7_rotl_wrap: assert (res_o[0] == opa_i[W-1])
        else $error("rotate left wrap bit wrong");
    end
    if (op_i == 4'b1101) begin
      a_r7_rotr_wrap: assert (res_o[W-1] == opa_i[0])
        else $error("rotate right wrap bit wrong");
    end
    if (op_i == 4'b1000) begin
      a_r5_sign_keep: assert (res_o[W-1] == opa_i[W-1])
        else $error("arith shift lost sign");
    end
    if (op_i == 4'b0001 && opa_i == opb_i) begin
      a_r2_equal_sub: assert (zero_o && carry_o && !ovf_o)
        else $error("equal subtract flags wrong");
    end
  end
endmodule

bind alu32_core alu32_checks #(.W(W)) u_checks (
  .opa_i  (opa_i),
  .opb_i  (opb_i),
  .op_i   (op_i),
  .res_o  (res_o),
  .zero_o (zero_o),
  .carry_o(carry_o),
  .ovf_o  (ovf_o)
);

// File: tb/tb_alu32_core.sv
module tb_alu32_core;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic [W-1:0] opa, opb;
  logic [3:0]   op;
  logic [W-1:0] res;
  logic         zf, cf, vf;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  alu32_core #(.W(W)) dut (
    .opa_i(opa), .opb_i(opb), .op_i(op),
    .res_o(res), .zero_o(zf), .carry_o(cf), .ovf_o(vf)
  );

  function automatic logic [W+2:0] ref_model(input logic [3:0] o,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] b);
    logic [W:0]   s;
    logic [W-1:0] r;
    logic         c, v;
    c = 1'b0; v = 1'b0; r = '0;
    case (o)
      4'b0000: begin
        s = {1'b0, a} + {1'b0, b}; r = s[W-1:0]; c = s[W];
        v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'b0001: begin
        r = a - b; c = (a >= b);
        v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
      end
      4'b0010: r = ~(a & b);
      4'b0011: r = a | b;
      4'b0100: r = ~a;
      4'b1000: r = $unsigned($signed(a) >>> 1);
      4'b1001: r = a >> 1;
      4'b1010: r = a << 1;
      4'b1100: r = {a[W-2:0], a[W-1]};
      4'b1101: r = {a[0], a[W-1:1]};
      default: r = '0;
    endcase
    return {r, (r == '0), c, v};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010, 4'b0011: return "R3";
      4'b0100: return "R4";
      4'b1000, 4'b1001: return "R5";
      4'b1010: return "R6";
      4'b1100, 4'b1101: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [W-1:0] a,
                       input logic [W-1:0] b);
    logic [W+2:0] exp_v;
    @(negedge clk);
    op = o; opa = a; opb = b;
    #2;
    exp_v = ref_model(o, a, b);
    n_run++;
    if ({res, zf, cf, vf} !== exp_v) begin
      n_fail++;
      $display("FAIL %s/R8/R9 op=%b a=%h b=%h got res=%h z=%b c=%b v=%b exp res=%h z=%b c=%b v=%b",
               tag_of(o), o, a, b, res, zf, cf, vf,
               exp_v[W+2:3], exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  function automatic logic [W-1:0] pick(input int unsigned k);
    case (k % 6)
      0: return 32'h8000_0000;
      1: return 32'h7FFF_FFFF;
      2: return 32'hFFFF_FFFF;
      3: return 32'h0000_0001;
      4: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1234));
    opa = '0; opb = '0; op = '0;
    // initial state: all-zero inputs, add -> zero result, zero flag (R8)
    apply(4'b0000, '0, '0);
    // R1: wrap to zero raises carry, overflow and zero together
    apply(4'b0000, 32'h8000_0000, 32'h8000_0000);
    apply(4'b0000, 32'h7FFF_FFFF, 32'h0000_0001);
    apply(4'b0000, 32'hFFFF_FFFF, 32'h0000_0001);
    // R2: equal operands, borrow, signed overflow
    apply(4'b0001, 32'h1234_5678, 32'h1234_5678);
    apply(4'b0001, 32'h0, 32'h1);
    apply(4'b0001, 32'h8000_0000, 32'h1);
    apply(4'b0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R3 NAND of all ones gives zero
    apply(4'b0010, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    apply(4'b0011, 32'h0F0F_0000, 32'h00F0_F0F0);
    // R4: B ignored - two different B values, same A
    apply(4'b0100, 32'hA5A5_0000, 32'h0);
    apply(4'b0100, 32'hA5A5_0000, 32'hFFFF_FFFF);
    // R5 sign fill and zero fill
    apply(4'b1000, 32'h8000_0001, 32'h0);
    apply(4'b1001, 32'h8000_0001, 32'h0);
    // R6 MSB dropped
    apply(4'b1010, 32'h8000_0000, 32'h0);
    // R7 wrap bits
    apply(4'b1100, 32'h8000_0000, 32'h0);
    apply(4'b1101, 32'h0000_0001, 32'h0);
    // R10 every unassigned code, with nonzero operands; R9 flags quiet
    foreach (ref_codes[i]) apply(ref_codes[i], 32'hFFFF_FFFF, 32'h1);
    // random mix over all 16 codes
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      apply(o, pick($urandom), pick($urandom));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  logic [3:0] ref_codes [6] = '{4'b0101, 4'b0110, 4'b0111,
                                4'b1011, 4'b1110, 4'b1111};

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule